// File: doc/BRIEF.md
# Oscillator Coarse-Calibration Controller

This block is the slow digital half of a two-loop tuning scheme for an injection-locked ring oscillator. An analog loop trims the oscillator through a fine-tune voltage. A window comparator watches that voltage and reports two flags: one when the voltage sits above its upper threshold, and one when it sits below its lower threshold. The controller turns those flags into single-step moves of a coarse frequency code. This brings the fine-tune voltage back toward the middle of its range while the analog loop keeps correcting.

The logic runs from its own low-frequency calibration clock. Both comparator flags pass through two flip-flops before use. A move is made only after one flag has persisted for a programmable number of slow cycles. The code starts from a preset value. It stops at either end of its range and raises an out-of-range flag instead of wrapping. A locked indication rises once the voltage has stayed inside the window long enough, and it drops on every step decision.

A four-state machine classifies each synchronised observation:
- `ST_IDLE`: entered whenever enable is low.
- `ST_INWIN`: neither flag is high, or both are high.
- `ST_HIGH`: only the over-high flag is high.
- `ST_LOW`: only the under-low flag is high.

Transitions:
- Leaving enable low forces `ST_IDLE`.
- Otherwise, every cycle the machine moves to the state of the current observation.
- Staying in `ST_HIGH` or `ST_LOW` advances a run counter. The counter fires a step when it reaches the dwell count, then restarts from zero.
- Any change of state restarts the run at one.

Top module: `osc_coarse_cal`

## Requirements
- R1: While rst_n is low, freq_code is 0, and locked and out_of_range are 0.
- R2: On every clock edge at which enable is low, freq_code loads preset_code, and locked and out_of_range are cleared.
- R3: Both comparator flags pass through a two-flip-flop synchroniser. A flag held high for K clock edges therefore has all of its resulting steps applied within three edges after it is released.
- R4: With enable high, an over_hi flag that stays high alone makes freq_code increase by one every Neff consecutive synchronised cycles. Neff is dwell_n, or 1 when dwell_n is 0. A flag held for K edges gives floor(K/Neff) step decisions.
- R5: With enable high, an under_lo flag that stays high alone makes freq_code decrease by one, with the same dwell rule as R4.
- R6: When both flags are high together, no step is taken, and the cycle counts as in-window.
- R7: An increment decision at code 2^CODE_W-1, or a decrement decision at code 0, leaves freq_code unchanged. It sets out_of_range, which stays set until enable is low.
- R8: locked rises after LOCK_M consecutive in-window synchronised cycles. It is cleared by every step decision, including one that saturation blocks.
- R9: Out-of-window cycles that end before a step decision do not clear locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency calibration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the loop when high; reloads preset when low |
| preset_code | input | CODE_W | Start value of the coarse code |
| dwell_n | input | DWELL_W | Persistence count before a step (0 acts as 1) |
| over_hi | input | 1 | Comparator: fine-tune voltage above high threshold (asynchronous) |
| under_lo | input | 1 | Comparator: fine-tune voltage below low threshold (asynchronous) |
| freq_code | output | CODE_W | Coarse frequency code to the oscillator |
| locked | output | 1 | Fine voltage has stayed in window for LOCK_M cycles |
| out_of_range | output | 1 | A step was blocked at a code limit |

## Verification
On every cycle, the assertions check the following:
- The code moves by at most one per enabled cycle.
- Disable reloads the preset and clears the flags.
- A blocked step at the upper limit holds the code and raises out_of_range.
- Up and down decisions never coincide.
- Every step decision is followed by locked low.
- locked only rises after an in-window cycle.

The exact step counts are shown only by the bench's sweeps. The bench covers dwell settings 0 to 4, burst lengths 0 to 7 in each direction, presets near both code limits, and both-flags bursts. In each case it shows the number of steps, the saturation value, the sticky range flag, and whether locked survives a short excursion.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INWIN = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } cal_state_t;
endpackage

// File: rtl/osc_cal_sync.sv
module osc_cal_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/osc_cal_dwell_fsm.sv
module osc_cal_dwell_fsm
    import osc_cal_pkg::*;
#(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DWELL_W-1:0] dwell_n,
    input  logic               hi_s,
    input  logic               lo_s,
    output logic               step_up,
    output logic               step_dn,
    output logic               in_win
);
    cal_state_t         state_q, state_nxt;
    logic [DWELL_W-1:0] run_q, run_nxt, n_eff;
    logic               fire;

    assign n_eff = (dwell_n == '0) ? DWELL_W'(1) : dwell_n;

    // next-state classification
    always_comb begin
        unique case ({enable, hi_s, lo_s})
            3'b110:  state_nxt = ST_HIGH;
            3'b101:  state_nxt = ST_LOW;
            3'b100,
            3'b111:  state_nxt = ST_INWIN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and run counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_nxt;
            run_q   <= fire ? '0 : run_nxt;
        end
    end

    // outputs
    always_comb begin
        run_nxt = (state_nxt == state_q) ? run_q + 1'b1 : DWELL_W'(1);
        fire    = 1'b0;
        step_up = 1'b0;
        step_dn = 1'b0;
        in_win  = 1'b0;
        unique case (state_nxt)
            ST_HIGH: begin
                fire    = (run_nxt >= n_eff);
                step_up = fire;
            end
            ST_LOW: begin
                fire    = (run_nxt >= n_eff);
                step_dn = fire;
            end
            ST_INWIN: in_win = 1'b1;
            default:  run_nxt = '0;
        endcase
    end

    assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));
endmodule

// File: rtl/osc_cal_code_reg.sv
module osc_cal_code_reg #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CODE_W-1:0] preset_code,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [CODE_W-1:0] code,
    output logic              range_flag
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code       <= '0;
            range_flag <= 1'b0;
        end else if (!enable) begin
            code       <= preset_code;
            range_flag <= 1'b0;
        end else if (step_up) begin
            if (code == CODE_MAX) range_flag <= 1'b1;
            else                  code <= code + 1'b1;
        end else if (step_dn) begin
            if (code == '0) range_flag <= 1'b1;
            else            code <= code - 1'b1;
        end
    end

    assert_single_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> (code == $past(code)) || (code == $past(code) + 1'b1)
                          || (code == $past(code) - 1'b1));
    assert_disable_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (code == $past(preset_code)) && !range_flag);
    assert_saturate_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && step_up && code == CODE_MAX) |=> (code == CODE_MAX) && range_flag);
endmodule

// File: rtl/osc_cal_lock.sv
module osc_cal_lock #(
    parameter int LOCK_M = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic in_win,
    input  logic step_any,
    output logic locked
);
    localparam int CNT_W = $clog2(LOCK_M + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_M);

    logic [CNT_W-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            locked  <= 1'b0;
        end else if (!enable || step_any) begin
            win_cnt <= '0;
            locked  <= 1'b0;
        end else if (in_win) begin
            if (win_cnt < CNT_TOP) win_cnt <= win_cnt + 1'b1;
            if (win_cnt + 1'b1 >= CNT_TOP) locked <= 1'b1;
        end else begin
            win_cnt <= '0;
        end
    end

    assert_step_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_any |=> !locked);
    assert_lock_after_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_win));
endmodule

// File: rtl/osc_coarse_cal.sv
module osc_coarse_cal #(
    parameter int CODE_W  = 6,
    parameter int DWELL_W = 8,
    parameter int LOCK_M  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [CODE_W-1:0]  preset_code,
    input  logic [DWELL_W-1:0] dwell_n,
    input  logic               over_hi,
    input  logic               under_lo,
    output logic [CODE_W-1:0]  freq_code,
    output logic               locked,
    output logic               out_of_range
);
    logic [1:0] flags_s;
    logic       step_up, step_dn, in_win;

    // R3: two-stage synchroniser for both comparator flags
    osc_cal_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({over_hi, under_lo}),
        .sync_out (flags_s)
    );

    osc_cal_dwell_fsm #(.DWELL_W(DWELL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .dwell_n (dwell_n),
        .hi_s    (flags_s[1]),
        .lo_s    (flags_s[0]),
        .step_up (step_up),
        .step_dn (step_dn),
        .in_win  (in_win)
    );

    osc_cal_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .preset_code (preset_code),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .code        (freq_code),
        .range_flag  (out_of_range)
    );

    osc_cal_lock #(.LOCK_M(LOCK_M)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .in_win   (in_win),
        .step_any (step_up | step_dn),
        .locked   (locked)
    );
endmodule

// File: tb/osc_coarse_cal_test.sv
module osc_coarse_cal_test;
    localparam int CW = 4;
    localparam int DW = 3;
    localparam int LM = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] preset_code = '0;
    logic [DW-1:0] dwell_n = '0;
    logic          over_hi = 1'b0, under_lo = 1'b0;
    logic [CW-1:0] freq_code;
    logic          locked, out_of_range;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    osc_coarse_cal #(.CODE_W(CW), .DWELL_W(DW), .LOCK_M(LM)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .preset_code(preset_code),
        .dwell_n(dwell_n), .over_hi(over_hi), .under_lo(under_lo),
        .freq_code(freq_code), .locked(locked), .out_of_range(out_of_range)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One trial: reload preset, wait for lock, apply a burst of K edges.
    // mode 0 = over_hi, 1 = under_lo, 2 = both flags
    task automatic trial(input int mode, input int n, input int k, input int pre);
        int neff, steps, raw, exp_code, exp_rng;
        neff  = (n == 0) ? 1 : n;
        steps = (mode == 2) ? 0 : k / neff;
        raw   = (mode == 0) ? pre + steps : (mode == 1) ? pre - steps : pre;
        exp_code = (raw > CMAX) ? CMAX : (raw < 0) ? 0 : raw;
        exp_rng  = (raw > CMAX || raw < 0) ? 1 : 0;

        enable = 1'b0; preset_code = CW'(pre); dwell_n = DW'(n);
        cycles(3);
        check("R2 reload", int'(freq_code), pre);
        check("R2 locked clear", int'(locked), 0);
        enable = 1'b1;
        cycles(LM + 4);
        check("R8 lock after window", int'(locked), 1);

        if (k > 0) begin
            over_hi  = (mode != 1);
            under_lo = (mode != 0);
            cycles(k);
            over_hi = 1'b0; under_lo = 1'b0;
        end
        cycles(3);
        if (mode == 0)      check("R4 up steps/R3 timing", int'(freq_code), exp_code);
        else if (mode == 1) check("R5 down steps/R3 timing", int'(freq_code), exp_code);
        else                check("R6 both flags no step", int'(freq_code), exp_code);
        check("R7 out_of_range", int'(out_of_range), exp_rng);
        if (steps == 0) check("R9 locked kept", int'(locked), 1);
        else            check("R8 locked cleared by step", int'(locked), 0);
        cycles(LM + 3);
        check("R8 relock", int'(locked), 1);
        check("R7 flag sticky", int'(out_of_range), exp_rng);
    endtask

    initial begin
        cycles(3);
        check("R1 reset code", int'(freq_code), 0);
        check("R1 reset locked", int'(locked), 0);
        check("R1 reset range", int'(out_of_range), 0);
        rst_n = 1'b1;
        cycles(2);
        for (int mode = 0; mode < 3; mode++)
            for (int n = 0; n <= 4; n++)
                for (int k = 0; k <= 7; k++)
                    for (int p = 0; p < 2; p++)
                        trial(mode, n, k,
                              (mode == 0) ? (p == 0 ? 1 : 13) :
                              (mode == 1) ? (p == 0 ? 14 : 2) : (p == 0 ? 0 : CMAX));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule